// File: doc/BRIEF.md
# Timer-Triggered Sample Sequencer Bank

This block holds four sample sequencers, each with a private 16-deep result FIFO. A single trigger input stands for a timer event. In a cycle where the trigger is high, every sequencer whose enable bit is set and whose 4-bit event-select nibble holds the timer code takes one sample. The sample is synthetic: a 32-bit linear congruential noise generator replaces the analog input, and the data word is derived from it. Every sample also sets that sequencer's raw interrupt bit. Each sequencer drives its own interrupt line, which is the raw bit gated by a mask bit.

Software uses a small register port. Writes take effect at the clock edge. A read returns its data one cycle later on `rdata`. Reading a sequencer's data register pops its FIFO. A status word gives the read pointer, the write pointer and the empty and full flags, each at a fixed position. Global registers hold the enables, the raw status, the mask, a write-one-to-clear view of the masked status and the event-select nibbles.

Top module: `trig_sampler`

## Requirements
- R1: After reset every FIFO status reads 0x100 (both pointers 0, empty set, full clear). The raw status reads 0, every interrupt line is low and every stored FIFO entry reads as 0.
- R2: The FIFO status word has the read pointer in bits 3:0, the write pointer in bits 7:4, empty at bit 8 and full at bit 12, with all other bits 0. A push into a full FIFO is dropped. Any other push stores the sample at the write pointer, advances it modulo 16, clears empty, and sets full when the new write pointer equals the read pointer.
- R3: Reading the data register at 0x48 + 0x20·n pops FIFO n. The read returns the entry at the read pointer, advances the pointer modulo 16, clears full, and sets empty when the new read pointer equals the write pointer. A pop of an empty FIFO returns the entry at the read pointer and moves nothing.
- R4: In a cycle with the trigger high, sequencer n samples only when bit n of the enable register (0x00) is set and bits 4n+3:4n of the event-select register (0x14) equal 5.
- R5: The noise state resets to 0. Each sample first replaces it with state·314159 + 1 (mod 2^32) and then pushes 0x200 + bits 18:16 of the new state. When several sequencers sample on one trigger, they are served in ascending index order, and each one advances the state. The state advances even when the push is dropped.
- R6: Each sample sets raw status bit n (register 0x04). Interrupt line n is high exactly when raw bit n and mask bit n (register 0x08, 4 bits) are both 1.
- R7: Reading register 0x0C returns raw AND mask. Writing it clears the raw bits written as 1. A sample in the same cycle sets its bit anyway.
- R8: The enable and mask registers keep 4 bits. The event-select register keeps 16 bits. Per-sequencer input-select registers at 0x40 + 0x20·n keep only the bits set in 0x33333333. Control registers at 0x44 + 0x20·n keep all 32 bits.
- R9: Read data appears on `rdata` in the cycle after `rd_en`, and it reflects the state before that read's own effects. Unmapped addresses read 0.
- R10: When a pop and a trigger hit the same FIFO in one cycle, the pop is applied first and the push second, so a full FIFO accepts the new sample.
- R11: FIFO status at 0x4C + 0x20·n is read-only and unaffected by reads other than the data pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Timer trigger; each cycle high is one event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 4 | Per-sequencer masked interrupt lines |

## Verification
The bench targets four cases. The first is a FIFO filled past 16 entries: a design that wraps without a full flag would overwrite the oldest sample and report empty. The second is a pop of an empty FIFO: a design that advances the pointer anyway would corrupt later reads. The third is a status clear landing on the same edge as a new sample: getting it wrong would lose an interrupt. The fourth is a pop and a push in the same cycle on a full FIFO: pushing first would drop the sample. It also checks that skipped sequencers leave the noise state alone while dropped pushes still advance it, since otherwise every later sample value would shift.

// File: rtl/trig_sampler_pkg.sv
package trig_sampler_pkg;

  localparam logic [31:0] LCG_MUL  = 32'd314159;
  localparam logic [31:0] LCG_INC  = 32'd1;
  localparam logic [3:0]  EV_TIMER = 4'd5;
  localparam logic [31:0] MUX_KEEP = 32'h3333_3333;
  localparam logic [11:0] SAMPLE_BASE = 12'h200;

  // global register offsets
  localparam int OFS_ENABLE = 'h00;
  localparam int OFS_RAW    = 'h04;
  localparam int OFS_MASK   = 'h08;
  localparam int OFS_CLEAR  = 'h0C;
  localparam int OFS_EVSEL  = 'h14;
  localparam int SEQ_BASE   = 'h40;
  localparam int SEQ_STRIDE = 'h20;

  // offsets inside one sequencer window
  localparam logic [4:0] SUB_MUX  = 5'h00;
  localparam logic [4:0] SUB_CTL  = 5'h04;
  localparam logic [4:0] SUB_DATA = 5'h08;
  localparam logic [4:0] SUB_STAT = 5'h0C;

  typedef struct packed {
    logic       full;
    logic       empty;
    logic [3:0] wp;
    logic [3:0] rp;
  } fifo_stat_t;

  function automatic logic [31:0] lcg_next(input logic [31:0] s);
    return s * LCG_MUL + LCG_INC;
  endfunction

  function automatic logic [31:0] pack_status(input fifo_stat_t st);
    return {19'b0, st.full, 3'b0, st.empty, st.wp, st.rp};
  endfunction

endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
  parameter int DATA_W = 10,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] head_data,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              empty,
  output logic              full
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [PTR_W-1:0] rp_q, wp_q, rp_a, rp_n, wp_n;
  logic             empty_q, full_q, empty_a, full_a, empty_n, full_n;
  logic             store;

  // pop is applied first, then the push sees the post-pop state
  always_comb begin
    rp_a    = rp_q;
    empty_a = empty_q;
    full_a  = full_q;
    if (pop && !empty_q) begin
      rp_a    = rp_q + PTR_W'(1);
      full_a  = 1'b0;
      empty_a = (rp_a == wp_q);
    end
    rp_n    = rp_a;
    wp_n    = wp_q;
    empty_n = empty_a;
    full_n  = full_a;
    store   = 1'b0;
    if (push && !full_a) begin
      store   = 1'b1;
      wp_n    = wp_q + PTR_W'(1);
      empty_n = 1'b0;
      full_n  = (wp_n == rp_a);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q    <= '0;
      wp_q    <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else if (pop || push) begin
      rp_q    <= rp_n;
      wp_q    <= wp_n;
      empty_q <= empty_n;
      full_q  <= full_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (store) begin
      mem_q[wp_q] <= push_data;
    end
  end

  assign head_data = mem_q[rp_q];
  assign rd_ptr    = rp_q;
  assign wr_ptr    = wp_q;
  assign empty     = empty_q;
  assign full      = full_q;

endmodule

// File: rtl/noise_gen.sv
module noise_gen
  import trig_sampler_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int DATA_W  = 10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SEQ-1:0]              take,
  output logic [NUM_SEQ-1:0][DATA_W-1:0]  sample
);
  logic [31:0]              state_q;
  logic [NUM_SEQ:0][31:0]   chain;

  assign chain[0] = state_q;

  // one generator step per sampling sequencer, ascending index order
  for (genvar n = 0; n < NUM_SEQ; n++) begin : g_step
    assign chain[n+1]  = take[n] ? lcg_next(chain[n]) : chain[n];
    assign sample[n]   = DATA_W'(SAMPLE_BASE) + DATA_W'(chain[n+1][18:16]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (|take) begin
      state_q <= chain[NUM_SEQ];
    end
  end

endmodule

// File: rtl/trig_sampler.sv
module trig_sampler
  import trig_sampler_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int DATA_W  = 10,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_SEQ-1:0] irq
);
  localparam int PTR_W   = 4;
  localparam int EV_W    = 4 * NUM_SEQ;
  localparam int IDX_W   = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1;
  localparam int SEQ_END = SEQ_BASE + NUM_SEQ * SEQ_STRIDE;

  logic [NUM_SEQ-1:0] en_q, en_n, mask_q, mask_n, raw_q, raw_n;
  logic [EV_W-1:0]    ev_q, ev_n;
  logic [NUM_SEQ-1:0][31:0] mux_q, mux_n, ctl_q, ctl_n;
  logic [31:0]        rdata_q, rdata_n;

  logic [NUM_SEQ-1:0]             take, pop_v;
  logic [NUM_SEQ-1:0][DATA_W-1:0] sample, head;
  logic [NUM_SEQ-1:0][PTR_W-1:0]  fifo_rp, fifo_wp;
  logic [NUM_SEQ-1:0]             fifo_empty, fifo_full;

  logic              seq_hit;
  logic [ADDR_W-1:0] seq_off;
  logic [IDX_W-1:0]  seq_idx;
  logic [4:0]        sub;

  // address decode
  assign seq_hit = (int'(addr) >= SEQ_BASE) && (int'(addr) < SEQ_END);
  assign seq_off = addr - ADDR_W'(SEQ_BASE);
  assign seq_idx = seq_off[5 +: IDX_W];
  assign sub     = addr[4:0];

  for (genvar n = 0; n < NUM_SEQ; n++) begin : g_seq
    assign take[n]  = trig && en_q[n] && (ev_q[4*n +: 4] == EV_TIMER);
    assign pop_v[n] = rd_en && seq_hit && (int'(seq_idx) == n) && (sub == SUB_DATA);

    seq_fifo #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop       (pop_v[n]),
      .push      (take[n]),
      .push_data (sample[n]),
      .head_data (head[n]),
      .rd_ptr    (fifo_rp[n]),
      .wr_ptr    (fifo_wp[n]),
      .empty     (fifo_empty[n]),
      .full      (fifo_full[n])
    );
  end

  noise_gen #(.NUM_SEQ(NUM_SEQ), .DATA_W(DATA_W)) u_noise (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .sample (sample)
  );

  // read mux, sampled before this cycle's updates
  always_comb begin
    fifo_stat_t st;
    rdata_n = '0;
    st      = '0;
    if (seq_hit) begin
      st.rp    = fifo_rp[seq_idx];
      st.wp    = fifo_wp[seq_idx];
      st.empty = fifo_empty[seq_idx];
      st.full  = fifo_full[seq_idx];
      case (sub)
        SUB_MUX:  rdata_n = mux_q[seq_idx];
        SUB_CTL:  rdata_n = ctl_q[seq_idx];
        SUB_DATA: rdata_n = 32'(head[seq_idx]);
        SUB_STAT: rdata_n = pack_status(st);
        default:  rdata_n = '0;
      endcase
    end else begin
      case (int'(addr))
        OFS_ENABLE: rdata_n = 32'(en_q);
        OFS_RAW:    rdata_n = 32'(raw_q);
        OFS_MASK:   rdata_n = 32'(mask_q);
        OFS_CLEAR:  rdata_n = 32'(raw_q & mask_q);
        OFS_EVSEL:  rdata_n = 32'(ev_q);
        default:    rdata_n = '0;
      endcase
    end
  end

  // register next state
  always_comb begin
    en_n   = en_q;
    mask_n = mask_q;
    ev_n   = ev_q;
    mux_n  = mux_q;
    ctl_n  = ctl_q;
    raw_n  = raw_q;
    if (wr_en) begin
      if (seq_hit) begin
        if (sub == SUB_MUX) mux_n[seq_idx] = wdata & MUX_KEEP;
        if (sub == SUB_CTL) ctl_n[seq_idx] = wdata;
      end else begin
        case (int'(addr))
          OFS_ENABLE: en_n   = wdata[NUM_SEQ-1:0];
          OFS_MASK:   mask_n = wdata[NUM_SEQ-1:0];
          OFS_CLEAR:  raw_n  = raw_q & ~wdata[NUM_SEQ-1:0];
          OFS_EVSEL:  ev_n   = wdata[EV_W-1:0];
          default:    ;
        endcase
      end
    end
    raw_n = raw_n | take;   // a new sample wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      ev_q   <= '0;
      mux_q  <= '0;
      ctl_q  <= '0;
    end else if (wr_en) begin
      en_q   <= en_n;
      mask_q <= mask_n;
      ev_q   <= ev_n;
      mux_q  <= mux_n;
      ctl_q  <= ctl_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (wr_en || trig) begin
      raw_q <= raw_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_n;
    end
  end

  assign rdata = rdata_q;
  assign irq   = raw_q & mask_q;

endmodule

// File: rtl/trig_sampler_chk.sv
module trig_sampler_chk #(
  parameter int NUM_SEQ = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          trig,
  input logic                          wr_en,
  input logic [NUM_SEQ-1:0]            irq,
  input logic [NUM_SEQ-1:0]            pop,
  input logic [NUM_SEQ-1:0]            empty,
  input logic [NUM_SEQ-1:0]            full,
  input logic [NUM_SEQ-1:0][3:0]       rd_ptr,
  input logic [NUM_SEQ-1:0][3:0]       wr_ptr,
  input logic [NUM_SEQ-1:0][31:0]      mux
);
  for (genvar n = 0; n < NUM_SEQ; n++) begin : g_chk
    assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty[n] && full[n]));

    assert_ptr_meet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (empty[n] || full[n]) |-> (rd_ptr[n] == wr_ptr[n]));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (full[n] && !pop[n]) |=> (full[n] && $stable(wr_ptr[n])));

    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (empty[n] && pop[n] && !trig) |=> ($stable(rd_ptr[n]) && empty[n]));

    assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig && !pop[n]) |=> ($stable(rd_ptr[n]) && $stable(wr_ptr[n]) && $stable(empty[n])));

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[n]) |-> ($past(trig) || $past(wr_en)));

    assert_mux_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mux[n] & ~32'h3333_3333) == 32'h0));
  end
endmodule

bind trig_sampler trig_sampler_chk #(.NUM_SEQ(NUM_SEQ)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .trig   (trig),
  .wr_en  (wr_en),
  .irq    (irq),
  .pop    (pop_v),
  .empty  (fifo_empty),
  .full   (fifo_full),
  .rd_ptr (fifo_rp),
  .wr_ptr (fifo_wp),
  .mux    (mux_q)
);

// File: tb/trig_sampler_tb_top.sv
module trig_sampler_tb_top;
  logic        clk;
  logic        rst_n;
  logic        trig;
  logic        wr_en;
  logic        rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference state
  bit [9:0]  m_data [4][16];
  int        m_rp [4];
  int        m_wp [4];
  bit        m_emp [4];
  bit        m_full [4];
  bit [31:0] m_mux [4];
  bit [31:0] m_ctl [4];
  bit [3:0]  m_en, m_mask, m_raw;
  bit [15:0] m_ev;
  bit [31:0] m_noise;
  bit [31:0] exp_rd;
  bit [31:0] rs = 32'h1234_5678;

  trig_sampler dut_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_rp[i] = 0; m_wp[i] = 0; m_emp[i] = 1; m_full[i] = 0;
      m_mux[i] = 0; m_ctl[i] = 0;
      for (int j = 0; j < 16; j++) m_data[i][j] = '0;
    end
    m_en = 0; m_mask = 0; m_raw = 0; m_ev = 0; m_noise = 0;
  endtask

  function automatic bit [31:0] stat_word(input int i);
    return {19'b0, m_full[i], 3'b0, m_emp[i], 4'(m_wp[i]), 4'(m_rp[i])};
  endfunction

  task automatic model_step(input bit w, input bit r, input bit [7:0] a,
                            input bit [31:0] d, input bit t);
    bit [3:0]  en0 = m_en;
    bit [15:0] ev0 = m_ev;
    bit        sq  = (a >= 8'h40) && (a < 8'hC0);
    int        ix  = (int'(a) - 'h40) >> 5;
    int        sb  = int'(a) & 31;
    bit [31:0] rv  = 0;
    if (r) begin
      if (sq) begin
        case (sb)
          0:  rv = m_mux[ix];
          4:  rv = m_ctl[ix];
          8:  rv = 32'(m_data[ix][m_rp[ix]]);
          12: rv = stat_word(ix);
          default: rv = 0;
        endcase
        if (sb == 8 && !m_emp[ix]) begin
          m_rp[ix] = (m_rp[ix] + 1) % 16;
          m_full[ix] = 0;
          m_emp[ix] = (m_rp[ix] == m_wp[ix]);
        end
      end else begin
        case (a)
          8'h00: rv = 32'(m_en);
          8'h04: rv = 32'(m_raw);
          8'h08: rv = 32'(m_mask);
          8'h0C: rv = 32'(m_raw & m_mask);
          8'h14: rv = 32'(m_ev);
          default: rv = 0;
        endcase
      end
      exp_rd = rv;
    end
    if (w) begin
      if (sq) begin
        if (sb == 0) m_mux[ix] = d & 32'h3333_3333;
        if (sb == 4) m_ctl[ix] = d;
      end else begin
        case (a)
          8'h00: m_en = d[3:0];
          8'h08: m_mask = d[3:0];
          8'h0C: m_raw = m_raw & ~d[3:0];
          8'h14: m_ev = d[15:0];
          default: ;
        endcase
      end
    end
    if (t) begin
      for (int i = 0; i < 4; i++) begin
        if (en0[i] && ev0[4*i +: 4] == 4'd5) begin
          m_noise = m_noise * 32'd314159 + 32'd1;
          if (!m_full[i]) begin
            m_data[i][m_wp[i]] = 10'h200 + 10'(m_noise[18:16]);
            m_wp[i] = (m_wp[i] + 1) % 16;
            m_emp[i] = 0;
            m_full[i] = (m_wp[i] == m_rp[i]);
          end
          m_raw[i] = 1'b1;
        end
      end
    end
  endtask

  // one clock: drive after negedge, check irq every cycle and rdata after reads
  task automatic cyc(input string tag, input bit w, input bit r, input bit [7:0] a,
                     input bit [31:0] d, input bit t);
    wr_en = w; rd_en = r; addr = a; wdata = d; trig = t;
    model_step(w, r, a, d, t);
    @(posedge clk); #5;
    check("R6 irq", 32'(irq), 32'(m_raw & m_mask));
    if (r) check(tag, rdata, exp_rd);
    @(negedge clk);
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    cyc("", 1, 0, a, d, 0);
  endtask

  task automatic rd(input string tag, input bit [7:0] a);
    cyc(tag, 0, 1, a, 0, 0);
  endtask

  task automatic pulse();
    cyc("", 0, 0, 0, 0, 1);
  endtask

  function automatic bit [31:0] rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  initial begin
    rst_n = 0; trig = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    model_reset();
    repeat (3) @(negedge clk);
    #5; check("R1 irq low in reset", 32'(irq), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) rd("R1 status after reset", 8'(8'h4C + 8'(i * 32)));
    rd("R1 raw after reset", 8'h04);
    rd("R1 entry zero after reset", 8'h48);

    // R8 field widths, R9 unmapped
    wr(8'h40, 32'hFFFF_FFFF); rd("R8 input select mask", 8'h40);
    wr(8'h64, 32'hDEAD_BEEF); rd("R8 control full width", 8'h64);
    wr(8'h00, 32'hFF);        rd("R8 enable 4 bits", 8'h00);
    wr(8'h14, 32'hFFFF_FFFF); rd("R8 event select 16 bits", 8'h14);
    rd("R9 unmapped reads zero", 8'h10);
    wr(8'h4C, 32'hFFFF_FFFF); rd("R11 status read only", 8'h4C);

    // R4 qualification: seq1 disabled, seq3 wrong event code
    wr(8'h14, 32'h4555);
    wr(8'h00, 32'b1101);
    wr(8'h08, 32'b0101);
    pulse();
    rd("R2 status after one push", 8'h4C);
    rd("R4 disabled sequencer empty", 8'h6C);
    rd("R4 other event code empty", 8'hAC);
    rd("R6 raw bits set", 8'h04);
    rd("R7 masked status read", 8'h0C);

    // R5 sample value, R3 pop and empty pop
    rd("R5 first sample value", 8'h48);
    rd("R3 empty pop returns entry at read pointer", 8'h48);
    rd("R3 empty pop leaves pointers", 8'h4C);

    // R2 fill seq2 past capacity
    repeat (17) pulse();
    rd("R2 full status", 8'h8C);
    for (int k = 0; k < 16; k++) rd("R3 drain order and values", 8'h88);
    rd("R3 empty after drain", 8'h8C);

    // R7 clear vs set on same edge
    cyc("", 1, 0, 8'h0C, 32'h1, 1);
    rd("R7 set wins over clear", 8'h04);
    wr(8'h0C, 32'hF);
    rd("R7 write-one clears", 8'h04);

    // R10 pop and push same cycle on a full FIFO
    wr(8'h00, 32'b0001);
    repeat (16) pulse();
    rd("R2 seq0 full", 8'h4C);
    cyc("R10 pop value with concurrent push", 0, 1, 8'h48, 0, 1);
    rd("R10 still full after pop then push", 8'h4C);

    // mixed traffic, all sequencers active
    wr(8'h00, 32'hF); wr(8'h14, 32'h5555); wr(8'h08, 32'hA);
    for (int k = 0; k < 600; k++) begin
      bit [31:0] v = rnd();
      bit [7:0]  a;
      int        ix = int'(v[3:2]);
      case (v[6:4])
        0, 1, 2: a = 8'(8'h48 + 8'(ix * 32));
        3, 4:    a = 8'(8'h4C + 8'(ix * 32));
        5:       a = 8'h0C;
        default: a = 8'h04;
      endcase
      if (v[9:7] == 0) cyc("R10 mixed traffic", 1, 0, (v[10] ? 8'h0C : 8'h14), 32'(v[31:16]), v[11]);
      else             cyc("R10 mixed traffic", 0, v[12] | v[13], a, 0, v[14] & v[15]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule